// File: doc/BRIEF.md
# High-Voltage Safety Interlock Controller

This block decides whether the high-voltage output stage of a grid simulation supply may run. It watches three permissive inputs (door closed, high-voltage connectors mated, interlock loop intact), a pair of normally closed emergency-stop contacts, a vector of digital fault flags from the protection comparators, a grid-loss flag, and two independent sample paths each for output voltage and current. From these it drives the output enable, the gate-drive block, the front-end grid connection, the main power contactor and the active discharge circuit.

Any hazard removes the output at once. It then runs the bleeder for a fixed supervised window. At the end of the window the sensed residual voltage is checked, and the block settles in a locked state. Every cause that has been seen stays in a sticky register until an operator reset is accepted. A reset is accepted only after the discharge window, with all permissives true and no hazard present. A separate enable request then restarts the output.

Top module: `hv_interlock_ctrl`

## Requirements
- R1: `hv_enable_o` is high only in the running state while door, connector and loop inputs are all 1. `enable_req_i` starts running only from the idle safe state with all permissives 1, no hazard present and `trip_cause_o` equal to 0. Out of reset the outputs are hv off, gate block on, discharge off, main power on, grid connected and no causes.
- R2: In the same cycle that any hazard input appears, `hv_enable_o` drops and `gate_block_o` rises. This does not wait for a clock edge.
- R3: A trip raises `discharge_o` at the next clock edge and holds it for exactly DISCH_CYCLES cycles. The block is then locked, and `enable_req_i` has no effect while it is locked.
- R4: Loss of any permissive while running latches cause bit 0. Permissives that are false while idle cause no trip.
- R5: Either emergency-stop contact reading 0 (open) drops `main_power_o` and blocks the gates in the same cycle, and latches cause bit 1. Main power stays off until a reset is accepted.
- R6: A disagreement between the two contacts that lasts ESTOP_SKEW_CYCLES consecutive cycles latches cause bit 2. A shorter disagreement does not set it.
- R7: Voltage paths differing by more than V_DIFF_MAX latch cause bit 3. Current paths differing by more than I_DIFF_MAX latch cause bit 4. A difference equal to the limit does not trip, and either sign of difference counts.
- R8: `grid_loss_i` drops `grid_connect_o` in the same cycle and latches cause bit 5. The grid stays disconnected until a reset is accepted.
- R9: Any bit set in `fault_flags_i` latches cause bit 6 and sets the same bit position of `fault_latched_o`. That bit stays set after the flag clears.
- R10: If `bus_v_i` exceeds SAFE_V at the clock edge that ends the discharge window, cause bit 7 is latched. A value equal to SAFE_V does not set it.
- R11: Cause bits never clear except through an accepted reset. `reset_req_i` is accepted only in the locked state, with all permissives 1 and no hazard. Accepting it clears `trip_cause_o` and `fault_latched_o`. A reset during discharge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| door_closed_i | input | 1 | Enclosure door closed permissive |
| conn_mated_i | input | 1 | High-voltage connectors mated permissive |
| loop_intact_i | input | 1 | Interlock loop continuity permissive |
| estop_a_ok_i | input | 1 | Emergency-stop contact A, 1 = closed |
| estop_b_ok_i | input | 1 | Emergency-stop contact B, 1 = closed |
| fault_flags_i | input | NUM_FAULTS | Per-source protection fault flags |
| grid_loss_i | input | 1 | Grid power loss detected |
| samp_v_a_i | input | SAMPLE_W | Output voltage, sample path A |
| samp_v_b_i | input | SAMPLE_W | Output voltage, sample path B |
| samp_i_a_i | input | SAMPLE_W | Output current, sample path A |
| samp_i_b_i | input | SAMPLE_W | Output current, sample path B |
| bus_v_i | input | SAMPLE_W | Sensed residual bus/output voltage |
| enable_req_i | input | 1 | Request to start high-voltage output |
| reset_req_i | input | 1 | Operator trip reset |
| hv_enable_o | output | 1 | High-voltage output enable |
| gate_block_o | output | 1 | Block all gate drive signals |
| grid_connect_o | output | 1 | Front-end rectifier grid contactor close |
| main_power_o | output | 1 | Main power contactor close |
| discharge_o | output | 1 | Active discharge circuit on |
| trip_cause_o | output | 8 | Sticky trip causes |
| fault_latched_o | output | NUM_FAULTS | Sticky per-source fault record |

## Verification
The hardest case to reach is the discharge-failure latch. It needs a trip, a residual voltage held above the safe level across the whole window, and a sample at the single edge where the window closes. The bench trips on a permissive loss while holding `bus_v_i` one count above SAFE_V, then counts the window out edge by edge. It repeats the same sequence with the voltage exactly at SAFE_V. A contact skew that is long enough to count as a wiring fault is also only reachable from the ports by holding one contact open for more than the skew limit. A short open contact gives the contrasting case.

// File: rtl/hvi_pkg.sv
package hvi_pkg;
    localparam int CAUSE_W = 8;

    // Cause bit positions; software and the bench decode these.
    localparam int C_PERMIT  = 0;
    localparam int C_ESTOP   = 1;
    localparam int C_WIRING  = 2;
    localparam int C_VMIS    = 3;
    localparam int C_IMIS    = 4;
    localparam int C_GRID    = 5;
    localparam int C_DEVICE  = 6;
    localparam int C_DFAIL   = 7;

    typedef enum logic [1:0] {
        ST_SAFE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DISCH  = 2'd2,
        ST_LOCKED = 2'd3
    } hvi_state_e;
endpackage

// File: rtl/hvi_estop_monitor.sv
module hvi_estop_monitor #(
    parameter int SKEW_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic contact_a_i,
    input  logic contact_b_i,
    output logic open_o,
    output logic skew_o
);
    localparam int CNT_W = $clog2(SKEW_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             disagree;

    assign disagree = contact_a_i ^ contact_b_i;
    assign open_o   = !(contact_a_i && contact_b_i);
    assign skew_o   = (cnt_q == CNT_W'(SKEW_CYCLES));

    always_comb begin
        if (!disagree)
            cnt_d = '0;
        else if (cnt_q == CNT_W'(SKEW_CYCLES))
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hvi_sample_compare.sv
module hvi_sample_compare #(
    parameter int W     = 12,
    parameter int LIMIT = 40
) (
    input  logic [W-1:0] path_a_i,
    input  logic [W-1:0] path_b_i,
    output logic         exceed_o
);
    logic [W:0] diff;

    always_comb begin
        if (path_a_i >= path_b_i) diff = {1'b0, path_a_i} - {1'b0, path_b_i};
        else                      diff = {1'b0, path_b_i} - {1'b0, path_a_i};
        exceed_o = diff > (W+1)'(LIMIT);
    end
endmodule

// File: rtl/hv_interlock_ctrl.sv
module hv_interlock_ctrl
    import hvi_pkg::*;
#(
    parameter int SAMPLE_W     = 12,
    parameter int NUM_FAULTS   = 12,
    parameter int V_DIFF_MAX   = 40,
    parameter int I_DIFF_MAX   = 20,
    parameter int SAFE_V       = 60,
    parameter int DISCH_CYCLES = 12500000,
    parameter int ESTOP_SKEW_CYCLES = 1250000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  door_closed_i,
    input  logic                  conn_mated_i,
    input  logic                  loop_intact_i,
    input  logic                  estop_a_ok_i,
    input  logic                  estop_b_ok_i,
    input  logic [NUM_FAULTS-1:0] fault_flags_i,
    input  logic                  grid_loss_i,
    input  logic [SAMPLE_W-1:0]   samp_v_a_i,
    input  logic [SAMPLE_W-1:0]   samp_v_b_i,
    input  logic [SAMPLE_W-1:0]   samp_i_a_i,
    input  logic [SAMPLE_W-1:0]   samp_i_b_i,
    input  logic [SAMPLE_W-1:0]   bus_v_i,
    input  logic                  enable_req_i,
    input  logic                  reset_req_i,
    output logic                  hv_enable_o,
    output logic                  gate_block_o,
    output logic                  grid_connect_o,
    output logic                  main_power_o,
    output logic                  discharge_o,
    output logic [7:0]            trip_cause_o,
    output logic [NUM_FAULTS-1:0] fault_latched_o
);
    localparam int CNT_W = (DISCH_CYCLES > 1) ? $clog2(DISCH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DISCH_CYCLES - 1);

    typedef struct packed {
        hvi_state_e            st;
        logic [CNT_W-1:0]      cnt;
        logic [CAUSE_W-1:0]    cause;
        logic [NUM_FAULTS-1:0] flt;
    } regs_t;

    regs_t r_d, r_q;

    logic estop_open, estop_skew, v_mis, i_mis;
    logic permit_ok, hazard, bus_unsafe;
    logic [CAUSE_W-1:0] cond;

    hvi_estop_monitor #(.SKEW_CYCLES(ESTOP_SKEW_CYCLES)) u_estop (
        .clk         (clk),
        .rst_n       (rst_n),
        .contact_a_i (estop_a_ok_i),
        .contact_b_i (estop_b_ok_i),
        .open_o      (estop_open),
        .skew_o      (estop_skew)
    );

    hvi_sample_compare #(.W(SAMPLE_W), .LIMIT(V_DIFF_MAX)) u_vcmp (
        .path_a_i (samp_v_a_i),
        .path_b_i (samp_v_b_i),
        .exceed_o (v_mis)
    );

    hvi_sample_compare #(.W(SAMPLE_W), .LIMIT(I_DIFF_MAX)) u_icmp (
        .path_a_i (samp_i_a_i),
        .path_b_i (samp_i_b_i),
        .exceed_o (i_mis)
    );

    assign permit_ok  = door_closed_i && conn_mated_i && loop_intact_i;
    assign bus_unsafe = bus_v_i > SAMPLE_W'(SAFE_V);

    always_comb begin
        cond           = '0;
        cond[C_PERMIT] = (r_q.st == ST_RUN) && !permit_ok;
        cond[C_ESTOP]  = estop_open;
        cond[C_WIRING] = estop_skew;
        cond[C_VMIS]   = v_mis;
        cond[C_IMIS]   = i_mis;
        cond[C_GRID]   = grid_loss_i;
        cond[C_DEVICE] = |fault_flags_i;
        hazard         = |cond;
    end

    // Outputs that must react without waiting for an edge.
    assign hv_enable_o     = (r_q.st == ST_RUN) && permit_ok && !hazard;
    assign gate_block_o    = !hv_enable_o;
    assign main_power_o    = !estop_open && !r_q.cause[C_ESTOP];
    assign grid_connect_o  = !grid_loss_i && !r_q.cause[C_GRID];
    assign discharge_o     = (r_q.st == ST_DISCH);
    assign trip_cause_o    = r_q.cause;
    assign fault_latched_o = r_q.flt;

    always_comb begin
        r_d       = r_q;
        r_d.cause = r_q.cause | cond;
        r_d.flt   = r_q.flt | fault_flags_i;
        unique case (r_q.st)
            ST_SAFE: begin
                if (hazard) begin
                    r_d.st  = ST_DISCH;
                    r_d.cnt = '0;
                end else if (enable_req_i && permit_ok && (r_q.cause == '0)) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (hazard) begin
                    r_d.st  = ST_DISCH;
                    r_d.cnt = '0;
                end
            end
            ST_DISCH: begin
                if (r_q.cnt == CNT_LAST) begin
                    r_d.st = ST_LOCKED;
                    if (bus_unsafe) r_d.cause[C_DFAIL] = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_LOCKED: begin
                if (reset_req_i && permit_ok && !hazard) begin
                    r_d.st    = ST_SAFE;
                    r_d.cause = '0;
                    r_d.flt   = '0;
                end
            end
            default: r_d.st = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_SAFE;
            r_q.cnt   <= '0;
            r_q.cause <= '0;
            r_q.flt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/hvi_checker.sv
module hvi_checker #(
    parameter int SAMPLE_W   = 12,
    parameter int NUM_FAULTS = 12,
    parameter int SAFE_V     = 60
) (
    input logic                clk,
    input logic                rst_n,
    input logic                door_closed_i,
    input logic                conn_mated_i,
    input logic                loop_intact_i,
    input logic                estop_a_ok_i,
    input logic                estop_b_ok_i,
    input logic                grid_loss_i,
    input logic [SAMPLE_W-1:0] bus_v_i,
    input logic                reset_req_i,
    input logic                hv_enable_o,
    input logic                gate_block_o,
    input logic                grid_connect_o,
    input logic                main_power_o,
    input logic                discharge_o,
    input logic [7:0]          trip_cause_o
);
    assert_permit_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hv_enable_o |-> (door_closed_i && conn_mated_i && loop_intact_i));

    assert_trip_discharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|trip_cause_o) |-> discharge_o);

    assert_estop_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(estop_a_ok_i && estop_b_ok_i) |-> (!main_power_o && gate_block_o && !hv_enable_o));

    assert_grid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        grid_loss_i |-> (!grid_connect_o && !hv_enable_o));

    assert_disch_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(discharge_o) && ($past(bus_v_i) > SAMPLE_W'(SAFE_V))) |-> trip_cause_o[7]);

    assert_sticky_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reset_req_i) |-> ((trip_cause_o & $past(trip_cause_o)) == $past(trip_cause_o)));
endmodule

bind hv_interlock_ctrl hvi_checker #(
    .SAMPLE_W(SAMPLE_W), .NUM_FAULTS(NUM_FAULTS), .SAFE_V(SAFE_V)
) u_hvi_checker (
    .clk(clk), .rst_n(rst_n),
    .door_closed_i(door_closed_i), .conn_mated_i(conn_mated_i), .loop_intact_i(loop_intact_i),
    .estop_a_ok_i(estop_a_ok_i), .estop_b_ok_i(estop_b_ok_i),
    .grid_loss_i(grid_loss_i), .bus_v_i(bus_v_i), .reset_req_i(reset_req_i),
    .hv_enable_o(hv_enable_o), .gate_block_o(gate_block_o), .grid_connect_o(grid_connect_o),
    .main_power_o(main_power_o), .discharge_o(discharge_o), .trip_cause_o(trip_cause_o)
);

// File: tb/tb_hv_interlock_ctrl.sv
`timescale 1ns/1ps
module tb_hv_interlock_ctrl;
    localparam int SW    = 12;
    localparam int NF    = 12;
    localparam int VLIM  = 20;
    localparam int ILIM  = 10;
    localparam int SAFE  = 50;
    localparam int DISCH = 100;
    localparam int SKEW  = 40;

    logic clk = 0, rst_n = 0;
    logic door, conn, loopi, ea, eb, gloss, en_req, rst_req;
    logic [NF-1:0] flags;
    logic [SW-1:0] va, vb, ia, ib, busv;
    logic hv, gblk, gconn, mpwr, disc;
    logic [7:0] cause;
    logic [NF-1:0] flt;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hv_interlock_ctrl #(
        .SAMPLE_W(SW), .NUM_FAULTS(NF), .V_DIFF_MAX(VLIM), .I_DIFF_MAX(ILIM),
        .SAFE_V(SAFE), .DISCH_CYCLES(DISCH), .ESTOP_SKEW_CYCLES(SKEW)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .door_closed_i(door), .conn_mated_i(conn), .loop_intact_i(loopi),
        .estop_a_ok_i(ea), .estop_b_ok_i(eb), .fault_flags_i(flags),
        .grid_loss_i(gloss), .samp_v_a_i(va), .samp_v_b_i(vb),
        .samp_i_a_i(ia), .samp_i_b_i(ib), .bus_v_i(busv),
        .enable_req_i(en_req), .reset_req_i(rst_req),
        .hv_enable_o(hv), .gate_block_o(gblk), .grid_connect_o(gconn),
        .main_power_o(mpwr), .discharge_o(disc),
        .trip_cause_o(cause), .fault_latched_o(flt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic defaults();
        door = 1; conn = 1; loopi = 1; ea = 1; eb = 1; gloss = 0;
        flags = '0; va = 500; vb = 500; ia = 100; ib = 100; busv = SAFE;
        en_req = 0; rst_req = 0;
    endtask

    task automatic arm(input string req);
        en_req = 1; cyc(1); en_req = 0;
        check(req, "hv after enable", hv, 1);
    endtask

    task automatic recover(input string req);
        defaults();
        cyc(DISCH + 3);
        rst_req = 1; cyc(1); rst_req = 0;
        check(req, "cause after reset", cause, 0);
    endtask

    task automatic t_reset_state();
        check("R1", "hv at reset", hv, 0);
        check("R1", "gate block at reset", gblk, 1);
        check("R1", "discharge at reset", disc, 0);
        check("R1", "cause at reset", cause, 0);
        check("R1", "main power at reset", mpwr, 1);
        check("R1", "grid at reset", gconn, 1);
    endtask

    task automatic t_idle_permit();
        door = 0; en_req = 1; cyc(1); en_req = 0; cyc(1);
        check("R1", "hv with door open", hv, 0);
        check("R4", "no trip while idle", cause, 0);
        check("R4", "no discharge while idle", disc, 0);
        door = 1; cyc(1);
    endtask

    task automatic t_interlock();
        arm("R1");
        loopi = 0; #1;
        check("R2", "hv same cycle", hv, 0);
        check("R2", "gate block same cycle", gblk, 1);
        cyc(1);
        check("R3", "discharge starts", disc, 1);
        check("R4", "permit cause bit0", cause, 8'h01);
        cyc(DISCH - 1);
        check("R3", "discharge last cycle", disc, 1);
        cyc(1);
        check("R3", "discharge ended", disc, 0);
        check("R10", "no fail at SAFE_V", cause, 8'h01);
        en_req = 1; cyc(1); en_req = 0; cyc(1);
        check("R3", "enable ignored when locked", hv, 0);
        rst_req = 1; cyc(1); rst_req = 0;
        check("R11", "reset refused with loop open", cause, 8'h01);
        loopi = 1; rst_req = 1; cyc(1); rst_req = 0;
        check("R11", "reset accepted", cause, 0);
        arm("R1");
    endtask

    task automatic t_estop_short();
        ea = 0; #1;
        check("R5", "main power same cycle", mpwr, 0);
        check("R5", "gate block", gblk, 1);
        cyc(3); ea = 1; cyc(1);
        check("R6", "short skew no wiring bit", cause, 8'h02);
        check("R5", "main power held off", mpwr, 0);
        recover("R11");
        check("R5", "main power restored", mpwr, 1);
    endtask

    task automatic t_estop_wiring();
        arm("R1");
        eb = 0; cyc(SKEW + 5);
        check("R6", "wiring bit after long skew", cause, 8'h06);
        recover("R11");
    endtask

    task automatic t_mismatch();
        arm("R1");
        vb = 500 + VLIM; ia = 100 + ILIM; cyc(3);
        check("R7", "diff at limit keeps running", hv, 1);
        check("R7", "diff at limit no cause", cause, 0);
        vb = 500 + VLIM + 1; cyc(1);
        check("R7", "voltage mismatch bit3", cause, 8'h08);
        recover("R11");
        arm("R1");
        ib = 100 - ILIM - 1; cyc(1);
        check("R7", "current mismatch bit4", cause, 8'h10);
        recover("R11");
    endtask

    task automatic t_grid();
        arm("R1");
        gloss = 1; #1;
        check("R8", "grid drop same cycle", gconn, 0);
        check("R2", "hv off on grid loss", hv, 0);
        cyc(1);
        check("R8", "grid cause bit5", cause, 8'h20);
        gloss = 0; cyc(1);
        check("R8", "grid held open", gconn, 0);
        recover("R11");
        check("R8", "grid reconnected", gconn, 1);
    endtask

    task automatic t_fault();
        arm("R1");
        flags = 12'h080; cyc(1);
        check("R9", "device cause bit6", cause, 8'h40);
        check("R9", "fault record bit7", flt, 12'h080);
        flags = '0; cyc(2);
        check("R9", "fault record sticky", flt, 12'h080);
        recover("R11");
        check("R11", "fault record cleared", flt, 0);
    endtask

    task automatic t_disch_fail();
        arm("R1");
        busv = SAFE + 1; door = 0; cyc(1);
        check("R4", "permit cause", cause, 8'h01);
        cyc(DISCH);
        check("R10", "discharge failure bit7", cause, 8'h81);
        recover("R11");
    endtask

    task automatic t_reset_in_discharge();
        arm("R1");
        door = 0; cyc(1); door = 1;
        rst_req = 1; cyc(1); rst_req = 0;
        check("R11", "reset ignored in discharge", cause, 8'h01);
        check("R11", "still discharging", disc, 1);
        recover("R11");
    endtask

    initial begin
        defaults();
        cyc(3); rst_n = 1; cyc(1);
        t_reset_state();
        t_idle_permit();
        t_interlock();
        t_estop_short();
        t_estop_wiring();
        t_mismatch();
        t_grid();
        t_fault();
        t_disch_fail();
        t_reset_in_discharge();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule